// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial input line back into characters. It gets a strobe from outside that pulses once per clock at eight times the bit rate. It finds the start bit and samples each bit near its centre. It checks the optional parity bit and the stop bit, and then offers the character to a receive queue that lives outside the block. Parity, framing and break faults are reported through one shared error bit. A character that arrives while the queue is full raises a separate overrun pulse.

The frame format comes from two configuration inputs. One is a 2-bit length code that selects 5 to 8 data bits. The other is a 3-bit parity code, with the same encoding the matching transmitter uses. When hardware flow control is enabled, the block also produces a ready-to-receive level from the free space the queue reports. Baud generation, queue storage and register decode belong to neighbouring blocks.

Top module: `serial_rx8`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `push_valid` and `overrun` are 0 and `rts` is 1.
- R2: `cfg_len` value k (0 to 3) selects 5+k data bits. The bits are received least significant first and appear in `push_data[4+k:0]`, and every higher bit of `push_data` is 0.
- R3: A `cfg_par` value of 0 to 3 means there is no parity bit. Value 4 means odd parity, 5 means the parity bit must be 1, 6 means even parity and 7 means the parity bit must be 0. If the received parity bit does not match, `push_err` is set for that character.
- R4: A stop bit sampled at 0 sets `push_err` for that character.
- R5: A character whose data bits are all 0 and whose stop bit is 0 is a break. It is delivered once with `push_err` set. No new start bit is looked for until the line has returned to 1.
- R6: A start bit is accepted only if the line is still 0 four strobes after the falling edge is first seen. A shorter low pulse produces no character.
- R7: If `fifo_full` is high when the stop bit is sampled, the character is not pushed and `overrun` pulses for one cycle. `push_valid` and `overrun` are never high together.
- R8: Each accepted frame gives exactly one single-cycle output event, which is either `push_valid` or `overrun`.
- R9: When `flow_en` is 0, `rts` is 1. When `flow_en` is 1, `rts` is 1 exactly when `fifo_room` was greater than 2 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | One-cycle strobe at eight times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code, where k selects 5+k bits |
| cfg_par | input | 3 | Parity code: 0-3 none, 4 odd, 5 one, 6 even, 7 zero |
| flow_en | input | 1 | Enables flow control on `rts` |
| fifo_full | input | 1 | The receive queue cannot accept a character |
| fifo_room | input | RW | Free entries in the receive queue |
| push_valid | output | 1 | Write strobe to the receive queue |
| push_data | output | 8 | Received character, zero-extended |
| push_err | output | 1 | Shared parity, framing or break error for the character |
| overrun | output | 1 | A character was lost because the queue was full |
| rts | output | 1 | Ready-to-receive level sent to the far end |

## Verification
The bench sends a short low pulse that is shorter than the start-bit qualification. A receiver that skipped the mid-start check would produce a bogus character from it. It also sends a break and keeps the line low long after the stop bit. A receiver that went straight back to idle would then report extra all-zero frames. Every parity mode is run with a correct and a flipped parity bit, and every length code is run with data whose upper bits are set, which catches a wrong bit count, wrong bit order or bits that were not masked. Overrun frames and `rts` at the room threshold of 2 and 3 catch decisions made on the wrong side of the boundary.

// File: rtl/serial_rx8_pkg.sv
package serial_rx8_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_e;

  localparam logic [2:0] PAR_ODD   = 3'd4;
  localparam logic [2:0] PAR_ONE   = 3'd5;
  localparam logic [2:0] PAR_EVEN  = 3'd6;
  localparam logic [2:0] PAR_ZERO  = 3'd7;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              err;
  } rx_char_t;

  // Parity bit a correct sender would place after the given data.
  function automatic logic want_par(input logic [DATA_W-1:0] d, input logic [2:0] mode);
    case (mode)
      PAR_ODD:  want_par = ~(^d);
      PAR_EVEN: want_par = ^d;
      PAR_ONE:  want_par = 1'b1;
      default:  want_par = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/serial_rx8_sync.sv
module serial_rx8_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_rx8_frame.sv
module serial_rx8_frame
  import serial_rx8_pkg::*;
#(
  parameter int OVERSAMPLE = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  output logic     done,
  output rx_char_t ch
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  rx_state_e         st;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_bad;
  logic [BW-1:0]     last_bit;
  logic              at_mid, at_end;

  assign last_bit = BW'(4) + BW'(cfg_len);
  assign at_mid   = tick && (tcnt == MID);
  assign at_end   = tick && (tcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bad <= 1'b0;
      done    <= 1'b0;
      ch      <= '0;
    end else begin
      done <= 1'b0;
      if (tick) tcnt <= tcnt + 1'b1;
      case (st)
        ST_IDLE: begin
          if (tick && !rx) begin
            st   <= ST_START;
            tcnt <= '0;
          end
        end
        ST_START: begin
          if (at_mid) begin
            if (!rx) begin
              st      <= ST_DATA;
              tcnt    <= '0;
              bidx    <= '0;
              shreg   <= '0;
              par_bad <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (at_end) begin
            shreg[bidx] <= rx;
            if (bidx == last_bit) st <= cfg_par[2] ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_end) begin
            par_bad <= (rx != want_par(shreg, cfg_par));
            st      <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (at_end) begin
            done    <= 1'b1;
            ch.data <= shreg;
            ch.err  <= par_bad | ~rx;
            st      <= (!rx && shreg == '0) ? ST_BRK : ST_IDLE;
          end
        end
        ST_BRK: begin
          if (rx) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx8_push.sv
module serial_rx8_push
  import serial_rx8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  rx_char_t          ch,
  input  logic              fifo_full,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic              push_err,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      push_err   <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      push_valid <= done & ~fifo_full;
      overrun    <= done &  fifo_full;
      if (done) begin
        push_data <= ch.data;
        push_err  <= ch.err;
      end
    end
  end
endmodule

// File: rtl/serial_rx8_rts.sv
module serial_rx8_rts #(
  parameter int RW     = 5,
  parameter int MARGIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_en,
  input  logic [RW-1:0] fifo_room,
  output logic          rts
);
  localparam logic [RW-1:0] LIMIT = RW'(MARGIN);

  always_ff @(posedge clk) begin
    if (rst) rts <= 1'b1;
    else     rts <= !flow_en || (fifo_room > LIMIT);
  end
endmodule

// File: rtl/serial_rx8.sv
module serial_rx8
  import serial_rx8_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH = 16,
  parameter int RTS_MARGIN = 2,
  parameter int RW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          rx_in,
  input  logic [1:0]    cfg_len,
  input  logic [2:0]    cfg_par,
  input  logic          flow_en,
  input  logic          fifo_full,
  input  logic [RW-1:0] fifo_room,
  output logic          push_valid,
  output logic [7:0]    push_data,
  output logic          push_err,
  output logic          overrun,
  output logic          rts
);
  logic     rx_s;
  logic     frm_done;
  rx_char_t frm_ch;

  serial_rx8_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (rx_in), .q (rx_s)
  );

  serial_rx8_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk (clk), .rst (rst), .tick (os_tick), .rx (rx_s),
    .cfg_len (cfg_len), .cfg_par (cfg_par),
    .done (frm_done), .ch (frm_ch)
  );

  serial_rx8_push u_push (
    .clk (clk), .rst (rst), .done (frm_done), .ch (frm_ch),
    .fifo_full (fifo_full), .push_valid (push_valid),
    .push_data (push_data), .push_err (push_err), .overrun (overrun)
  );

  serial_rx8_rts #(.RW(RW), .MARGIN(RTS_MARGIN)) u_rts (
    .clk (clk), .rst (rst), .flow_en (flow_en),
    .fifo_room (fifo_room), .rts (rts)
  );
endmodule

// File: rtl/serial_rx8_chk.sv
module serial_rx8_chk #(
  parameter int RW = 5,
  parameter int MARGIN = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_len,
  input logic          flow_en,
  input logic          fifo_full,
  input logic [RW-1:0] fifo_room,
  input logic          push_valid,
  input logic [7:0]    push_data,
  input logic          overrun,
  input logic          rts
);
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> ((16'(push_data) >> (5 + int'(cfg_len))) == 16'd0)); // R2

  AST_NO_PUSH_WITH_OVR: assert property (@(posedge clk) disable iff (rst)
    !(push_valid && overrun)); // R7

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(fifo_full)); // R7

  AST_PUSH_NEEDS_SPACE: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> !$past(fifo_full)); // R7

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    push_valid |=> !push_valid); // R8

  AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    overrun |=> !overrun); // R8

  AST_RTS_NO_FLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(flow_en) |-> rts); // R9

  AST_RTS_TIGHT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flow_en) && ($past(fifo_room) <= RW'(MARGIN))) |-> !rts); // R9
endmodule

bind serial_rx8 serial_rx8_chk #(.RW(RW), .MARGIN(RTS_MARGIN)) u_chk (
  .clk (clk), .rst (rst), .cfg_len (cfg_len), .flow_en (flow_en),
  .fifo_full (fifo_full), .fifo_room (fifo_room), .push_valid (push_valid),
  .push_data (push_data), .overrun (overrun), .rts (rts)
);

// File: tb/test_serial_rx8.sv
module test_serial_rx8;
  localparam int RW = $clog2(16 + 1);

  logic clk = 1'b0, rst = 1'b1, os_tick = 1'b0, rx_in = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic flow_en = 1'b0, fifo_full = 1'b0;
  logic [RW-1:0] fifo_room = RW'(16);
  logic push_valid, push_err, overrun, rts;
  logic [7:0] push_data;

  serial_rx8 i_serial_rx8 (
    .clk (clk), .rst (rst), .os_tick (os_tick), .rx_in (rx_in),
    .cfg_len (cfg_len), .cfg_par (cfg_par), .flow_en (flow_en),
    .fifo_full (fifo_full), .fifo_room (fifo_room), .push_valid (push_valid),
    .push_data (push_data), .push_err (push_err), .overrun (overrun), .rts (rts)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, tdiv = 0;
  logic [9:0] expq[$];
  string tagq[$];
  logic e_rst = 1'b1, e_en = 1'b0;
  logic [RW-1:0] e_room = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    os_tick <= (tdiv == 3);
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
  end

  always @(posedge clk) begin
    e_rst  <= rst;
    e_en   <= flow_en;
    e_room <= fifo_room;
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Reference comparison every cycle
  always @(negedge clk) begin
    if (!e_rst) begin
      logic exp_rts;
      exp_rts = !e_en || (e_room > RW'(2));
      check(rts == exp_rts, "R9", "rts", rts, exp_rts);
      if (push_valid || overrun) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8", "unexpected output event",
                {overrun, push_err, push_data}, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (e[9]) check(overrun && !push_valid, t, "overrun event",
                          {overrun, push_valid}, 2);
          else      check({overrun, push_err, push_data} == e, t, "pushed char",
                          {overrun, push_err, push_data}, e);
        end
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!os_tick) @(posedge clk);
    end
  endtask

  task automatic drive_bit(input logic v);
    @(negedge clk);
    rx_in = v;
    wait_ticks(8);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input logic stop_v, input string tag);
    int n;
    logic [7:0] m;
    logic p, pe, err;
    n  = 5 + int'(cfg_len);
    m  = 8'(int'(d) & ((1 << n) - 1));
    pe = cfg_par[2];
    case (cfg_par)
      3'd4:    p = ($countones(m) % 2 == 0);
      3'd6:    p = ($countones(m) % 2 == 1);
      3'd5:    p = 1'b1;
      default: p = 1'b0;
    endcase
    if (bad_par) p = ~p;
    err = (pe && bad_par) || !stop_v;
    if (fifo_full) expq.push_back({1'b1, 1'b0, 8'h00});
    else           expq.push_back({1'b0, err, m});
    tagq.push_back(tag);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    if (pe) drive_bit(p);
    drive_bit(stop_v);
    if (m == 8'h00 && !stop_v) wait_ticks(24);
    @(negedge clk);
    rx_in = 1'b1;
    wait_ticks(6);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    check(push_valid == 0 && overrun == 0 && rts == 1, "R1", "in reset",
          {push_valid, overrun, rts}, 1);
    rst = 1'b0;
    @(negedge clk);
    check(push_valid == 0 && overrun == 0 && rts == 1, "R1", "after reset",
          {push_valid, overrun, rts}, 1);
    wait_ticks(4);

    // R2: every length code, upper data bits set
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cfg_len = 2'(k);
      send_frame(8'hF5, 1'b0, 1'b1, "R2");
      send_frame(8'h2A, 1'b0, 1'b1, "R2");
    end

    // R3: parity codes, good and flipped, plus "none" code 3
    @(negedge clk); cfg_par = 3'd3; cfg_len = 2'd3;
    send_frame(8'h81, 1'b0, 1'b1, "R3");
    for (int c = 4; c < 8; c++) begin
      @(negedge clk); cfg_par = 3'(c);
      send_frame(8'h6B, 1'b0, 1'b1, "R3");
      send_frame(8'h6B, 1'b1, 1'b1, "R3");
      send_frame(8'h00, 1'b0, 1'b1, "R3");
    end
    @(negedge clk); cfg_len = 2'd1; cfg_par = 3'd4;
    send_frame(8'h15, 1'b1, 1'b1, "R3");
    send_frame(8'h15, 1'b0, 1'b1, "R3");

    // R4: stop bit low with nonzero data
    @(negedge clk); cfg_len = 2'd3; cfg_par = 3'd0;
    send_frame(8'h3C, 1'b0, 1'b0, "R4");
    send_frame(8'h5A, 1'b0, 1'b1, "R4");

    // R5: break, long low, then a normal character
    send_frame(8'h00, 1'b0, 1'b0, "R5");
    send_frame(8'hC3, 1'b0, 1'b1, "R5");

    // R6: short low pulse
    @(negedge clk); rx_in = 1'b0;
    wait_ticks(2);
    @(negedge clk); rx_in = 1'b1;
    wait_ticks(16);
    check(expq.size() == 0, "R6", "glitch produced no char", expq.size(), 0);
    send_frame(8'h99, 1'b0, 1'b1, "R6");

    // R7: overrun, then normal receive resumes
    @(negedge clk); fifo_full = 1'b1;
    send_frame(8'h47, 1'b0, 1'b1, "R7");
    @(negedge clk); fifo_full = 1'b0;
    send_frame(8'h74, 1'b0, 1'b1, "R7");

    // R9: rts threshold sweep
    @(negedge clk); fifo_room = '0;
    repeat (3) @(negedge clk);
    flow_en = 1'b1;
    for (int r = 0; r < 7; r++) begin
      @(negedge clk); fifo_room = RW'(r);
      repeat (3) @(negedge clk);
    end
    @(negedge clk); fifo_room = RW'(16);
    repeat (3) @(negedge clk);
    fifo_room = RW'(1);
    repeat (3) @(negedge clk);
    flow_en = 1'b0;
    repeat (3) @(negedge clk);

    wait_ticks(10);
    check(expq.size() == 0, "R8", "all frames delivered", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule